// File: doc/BRIEF.md
# Thread-Mask Instruction Splitter

This stage sits between decode and register renaming in a core that runs four hardware threads. Each instruction arrives carrying a 4-bit thread mask, in which bit i set means thread i fetched it. The stage decides how many execution copies the instruction needs so that each copy serves only threads whose source operands are known to hold equal values. A sharing table holds one bit per thread pair for each architected register. A 1 in a pair bit means the two threads hold equal values in that register.

In the accept cycle, the stage combines the pair bits of both sources with AND and builds the full partition of the thread mask. The partition is built greedily: at each step it takes the largest shared group that fits in the threads still left. In the same cycle it rewrites the destination register's pair bits to match the partition. The copies then leave one per cycle on a valid/ready stream, with the current copy's mask and the instruction's tag. Upstream sees `in_ready` low while any copy other than the final one is waiting. The handover is back to back: `in_ready` goes high in the same cycle that the final copy is taken. A copy that is offered stays unchanged until `out_ready` is high.

Top module: `mmt_splitter`

## Requirements
- R1: Synchronous reset (rst_n low at a clock edge) loads the table and empties the output. With mt_mode = 0, every pair bit of every register becomes 1. With mt_mode = 1, the register at index SP_IDX gets all pair bits 0 and every other register gets all 1.
- R2: A thread group counts as shared only if every pair inside it has a 1 in every enabled source register. A disabled source adds no constraint, so an instruction with no enabled source yields exactly one copy carrying its whole mask.
- R3: Every copy's mask is a subset of the incoming mask. The copies of one instruction are pairwise disjoint and together cover the incoming mask.
- R4: The copies come out in choice order. Each one is the shared group with the most threads among the threads not yet covered. When groups tie in size, the one with the smallest numeric mask value wins.
- R5: With in_dst_en high, each pair (a,b) with at least one of threads a, b in the incoming mask gets its destination bit set to 1 if some copy holds both threads, and to 0 otherwise.
- R6: Pair bits of pairs with neither thread in the mask keep their value. With in_dst_en low, the table does not change.
- R7: out_valid is high exactly while copies are pending. While out_ready is low, out_mask, out_tag and out_last hold steady. out_last is high on the final copy only.
- R8: in_ready is high when no copy is pending, or when exactly one copy is pending and out_ready is high. Otherwise it is low.
- R9: An instruction with mask 0000 is accepted, produces no copy and leaves the table unchanged.
- R10: Every copy carries the tag of its instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mt_mode | input | 1 | Reset flavour: 1 marks the stack-pointer register as unshared |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction taken when high together with in_valid |
| in_mask | input | 4 | Thread mask of the fetched instruction |
| in_src0_en | input | 1 | First source present |
| in_src0 | input | $clog2(NUM_REGS) | First source register index |
| in_src1_en | input | 1 | Second source present |
| in_src1 | input | $clog2(NUM_REGS) | Second source register index |
| in_dst_en | input | 1 | Destination present |
| in_dst | input | $clog2(NUM_REGS) | Destination register index |
| in_tag | input | TAG_W | Opaque payload copied to every copy |
| out_valid | output | 1 | Copy offered |
| out_ready | input | 1 | Copy taken when high together with out_valid |
| out_mask | output | 4 | Thread mask of the offered copy |
| out_tag | output | TAG_W | Tag of the instruction the copy belongs to |
| out_last | output | 1 | Offered copy is the final one of its instruction |

## Verification
The bench builds the block with NUM_REGS = 4, SP_IDX = 1 and TAG_W = 8. With only four registers, a few thousand pseudo-random instructions rewrite every register many times over. The pair patterns that result mix shared and unshared bits, and include inconsistent ones where the greedy tie rule decides the outcome. All sixteen thread masks are offered with random back-pressure, under both reset flavours. A bench-side model recomputes each partition and each table update by enumerating group sizes from four down to one.

// File: rtl/mmt_split_pkg.sv
package mmt_split_pkg;
  localparam int NTHR  = 4;
  localparam int NPAIR = NTHR * (NTHR - 1) / 2;
  localparam int NGRP  = (1 << NTHR) - 1;

  typedef logic [NTHR-1:0]  tmask_t;
  typedef logic [NPAIR-1:0] pairv_t;

  // pairs whose both threads lie inside g
  function automatic pairv_t inner_pairs(tmask_t g);
    pairv_t r;
    int p;
    r = '0;
    p = 0;
    for (int a = 0; a < NTHR; a++) begin
      for (int b = a + 1; b < NTHR; b++) begin
        r[p] = g[a] & g[b];
        p++;
      end
    end
    return r;
  endfunction

  // pairs with at least one thread inside g
  function automatic pairv_t touched_pairs(tmask_t g);
    pairv_t r;
    int p;
    r = '0;
    p = 0;
    for (int a = 0; a < NTHR; a++) begin
      for (int b = a + 1; b < NTHR; b++) begin
        r[p] = g[a] | g[b];
        p++;
      end
    end
    return r;
  endfunction

  function automatic logic group_shared(tmask_t g, pairv_t share);
    return (inner_pairs(g) & ~share) == '0;
  endfunction
endpackage

// File: rtl/mmt_share_table.sv
module mmt_share_table
  import mmt_split_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int SP_IDX   = 2,
  localparam int RW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mt_mode,
  input  logic [RW-1:0] rd0_idx,
  input  logic [RW-1:0] rd1_idx,
  output pairv_t        rd0_bits,
  output pairv_t        rd1_bits,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_idx,
  input  pairv_t        wr_touch,
  input  pairv_t        wr_val
);
  pairv_t tab [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++)
        tab[r] <= (mt_mode && (r == SP_IDX)) ? '0 : '1;
    end else if (wr_en) begin
      tab[wr_idx] <= (tab[wr_idx] & ~wr_touch) | (wr_val & wr_touch);
    end
  end

  assign rd0_bits = tab[rd0_idx];
  assign rd1_bits = tab[rd1_idx];
endmodule

// File: rtl/mmt_split_chooser.sv
module mmt_split_chooser
  import mmt_split_pkg::*;
(
  input  tmask_t remain,
  input  pairv_t share,
  output tmask_t pick,
  output tmask_t rest
);
  int best;

  // ascending scan with strict compare: smallest mask wins a size tie
  always_comb begin
    pick = '0;
    best = 0;
    for (int g = 1; g <= NGRP; g++) begin
      if (((tmask_t'(g) & ~remain) == '0) &&
          group_shared(tmask_t'(g), share) &&
          ($countones(tmask_t'(g)) > best)) begin
        pick = tmask_t'(g);
        best = $countones(tmask_t'(g));
      end
    end
  end

  assign rest = remain & ~pick;
endmodule

// File: rtl/mmt_copy_emitter.sv
module mmt_copy_emitter
  import mmt_split_pkg::*;
#(
  parameter int TAG_W = 8,
  localparam int CW   = $clog2(NTHR + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [NTHR-1:0][NTHR-1:0] load_masks,
  input  logic [CW-1:0]             load_cnt,
  input  logic [TAG_W-1:0]          load_tag,
  output logic                      can_load,
  output logic                      out_valid,
  input  logic                      out_ready,
  output tmask_t                    out_mask,
  output logic [TAG_W-1:0]          out_tag,
  output logic                      out_last
);
  logic [NTHR-1:0][NTHR-1:0] q;
  logic [CW-1:0]             cnt;
  logic [TAG_W-1:0]          tag_q;
  logic                      pop;

  assign pop       = out_valid && out_ready;
  assign can_load  = (cnt == '0) || ((cnt == CW'(1)) && out_ready);
  assign out_valid = (cnt != '0);
  assign out_last  = (cnt == CW'(1));
  assign out_mask  = q[0];
  assign out_tag   = tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q     <= '0;
      cnt   <= '0;
      tag_q <= '0;
    end else if (load) begin
      q     <= load_masks;
      cnt   <= load_cnt;
      tag_q <= load_tag;
    end else if (pop) begin
      q   <= {tmask_t'(0), q[NTHR-1:1]};
      cnt <= cnt - CW'(1);
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mask) &&
                                   $stable(out_tag) && $stable(out_last)));
  // R3
  copies_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !out_last) |=> (out_valid && ((out_mask & $past(out_mask)) == '0)));
  // R4
  size_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !out_last) |=> ($countones(out_mask) <= $countones($past(out_mask))));
  // R3
  copy_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask != '0));
endmodule

// File: rtl/mmt_splitter.sv
module mmt_splitter
  import mmt_split_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int SP_IDX   = 2,
  parameter int TAG_W    = 8,
  localparam int RW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int CW      = $clog2(NTHR + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mt_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_mask,
  input  logic             in_src0_en,
  input  logic [RW-1:0]    in_src0,
  input  logic             in_src1_en,
  input  logic [RW-1:0]    in_src1,
  input  logic             in_dst_en,
  input  logic [RW-1:0]    in_dst,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [3:0]       out_mask,
  output logic [TAG_W-1:0] out_tag,
  output logic             out_last
);
  pairv_t rd0_bits, rd1_bits, share, upd_val, upd_touch;
  logic   accept, can_load;
  tmask_t rem   [NTHR+1];
  tmask_t picks [NTHR];
  logic [NTHR-1:0][NTHR-1:0] load_masks;
  logic [CW-1:0] copy_cnt;

  assign in_ready = can_load;
  assign accept   = in_valid && can_load;

  mmt_share_table #(.NUM_REGS(NUM_REGS), .SP_IDX(SP_IDX)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .mt_mode  (mt_mode),
    .rd0_idx  (in_src0),
    .rd1_idx  (in_src1),
    .rd0_bits (rd0_bits),
    .rd1_bits (rd1_bits),
    .wr_en    (accept && in_dst_en),
    .wr_idx   (in_dst),
    .wr_touch (upd_touch),
    .wr_val   (upd_val)
  );

  assign share = (in_src0_en ? rd0_bits : '1) & (in_src1_en ? rd1_bits : '1);
  assign rem[0] = in_mask;

  for (genvar k = 0; k < NTHR; k++) begin : g_stage
    mmt_split_chooser u_choose (
      .remain (rem[k]),
      .share  (share),
      .pick   (picks[k]),
      .rest   (rem[k+1])
    );
    assign load_masks[k] = picks[k];
  end

  always_comb begin
    copy_cnt = '0;
    upd_val  = '0;
    for (int k = 0; k < NTHR; k++) begin
      if (picks[k] != '0) copy_cnt = copy_cnt + CW'(1);
      upd_val = upd_val | inner_pairs(picks[k]);
    end
    upd_touch = touched_pairs(in_mask);
  end

  mmt_copy_emitter #(.TAG_W(TAG_W)) u_emit (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_masks (load_masks),
    .load_cnt   (copy_cnt),
    .load_tag   (in_tag),
    .can_load   (can_load),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_mask   (out_mask),
    .out_tag    (out_tag),
    .out_last   (out_last)
  );

  // R8
  upstream_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> !in_ready);
  // R8
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  // R3
  first_copy_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_mask != '0)) |=> (out_valid && ((out_mask & ~$past(in_mask)) == '0)));
  // R10
  tag_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_mask != '0)) |=> (out_tag == $past(in_tag)));
endmodule

// File: tb/mmt_splitter_tb.sv
module mmt_splitter_tb;
  localparam int NR = 4, SPI = 1, TW = 8, RW = 2;

  logic clk = 1'b0, rst_n = 1'b0, mt_mode = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [3:0] in_mask = '0;
  logic in_src0_en = 1'b0, in_src1_en = 1'b0, in_dst_en = 1'b0;
  logic [RW-1:0] in_src0 = '0, in_src1 = '0, in_dst = '0;
  logic [TW-1:0] in_tag = '0;
  logic out_valid, out_ready = 1'b0, out_last;
  logic [3:0] out_mask;
  logic [TW-1:0] out_tag;

  always #10 clk = ~clk;

  mmt_splitter #(.NUM_REGS(NR), .SP_IDX(SPI), .TAG_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mt_mode(mt_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_mask(in_mask),
    .in_src0_en(in_src0_en), .in_src0(in_src0),
    .in_src1_en(in_src1_en), .in_src1(in_src1),
    .in_dst_en(in_dst_en), .in_dst(in_dst), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_mask(out_mask),
    .out_tag(out_tag), .out_last(out_last)
  );

  int n_tests = 0, n_fail = 0;
  logic [5:0] mtab [NR];
  logic [3:0] qm [256];
  logic [TW-1:0] qt [256];
  int qh = 0, qtl = 0;
  string cur_req = "R4";
  bit last_acc = 1'b0;
  bit done = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [31:0] nxt();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  function automatic int pid(int i, int j);
    return i * (7 - i) / 2 + (j - i - 1);
  endfunction

  function automatic bit grp_ok(int g, logic [5:0] pb);
    for (int i = 0; i < 4; i++)
      for (int j = i + 1; j < 4; j++)
        if (g[i] && g[j] && !pb[pid(i, j)]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset(bit mt);
    for (int r = 0; r < NR; r++) mtab[r] = (mt && r == SPI) ? 6'h00 : 6'h3f;
    qh = 0;
    qtl = 0;
  endtask

  task automatic model_accept();
    logic [5:0] pb, both;
    logic [3:0] rem;
    int pick;
    bit found;
    pb = 6'h3f;
    if (in_src0_en) pb &= mtab[in_src0];
    if (in_src1_en) pb &= mtab[in_src1];
    both = '0;
    rem = in_mask;
    while (rem != 0) begin
      found = 1'b0;
      pick = 0;
      for (int sz = 4; sz >= 1; sz--)
        for (int g = 1; g < 16; g++)
          if (!found && $countones(4'(g)) == sz && ((4'(g) & ~rem) == 0) && grp_ok(g, pb)) begin
            pick = g;
            found = 1'b1;
          end
      qm[qtl % 256] = 4'(pick);
      qt[qtl % 256] = in_tag;
      qtl++;
      for (int i = 0; i < 4; i++)
        for (int j = i + 1; j < 4; j++)
          if (pick[i] && pick[j]) both[pid(i, j)] = 1'b1;
      rem = rem & ~4'(pick);
    end
    if (in_dst_en)
      for (int i = 0; i < 4; i++)
        for (int j = i + 1; j < 4; j++)
          if (in_mask[i] || in_mask[j]) mtab[in_dst][pid(i, j)] = both[pid(i, j)];
  endtask

  task automatic cyc();
    int pend;
    bit exp_rdy;
    #1;
    pend = qtl - qh;
    chk(out_valid == (pend != 0), "R7", int'(out_valid), int'(pend != 0));
    if (pend != 0) begin
      chk(out_mask == qm[qh % 256], cur_req, int'(out_mask), int'(qm[qh % 256]));
      chk(out_tag == qt[qh % 256], "R10", int'(out_tag), int'(qt[qh % 256]));
      chk(out_last == (pend == 1), "R7", int'(out_last), int'(pend == 1));
    end
    exp_rdy = (pend == 0) || (pend == 1 && out_ready);
    if (in_valid) chk(in_ready == exp_rdy, "R8", int'(in_ready), int'(exp_rdy));
    last_acc = in_valid && exp_rdy;
    if (pend != 0 && out_ready) qh++;
    if (last_acc) model_accept();
    @(negedge clk);
  endtask

  task automatic issue(logic [3:0] m, bit s0e, int s0, bit s1e, int s1, bit de, int d,
                       logic [TW-1:0] tg, string req, int rdy_pct);
    cur_req = req;
    in_mask = m; in_src0_en = s0e; in_src0 = RW'(s0); in_src1_en = s1e; in_src1 = RW'(s1);
    in_dst_en = de; in_dst = RW'(d); in_tag = tg; in_valid = 1'b1;
    do begin
      out_ready = (nxt() % 100) < rdy_pct;
      cyc();
    end while (!last_acc);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    out_ready = 1'b1;
    while (qtl - qh != 0) cyc();
    cyc();
  endtask

  task automatic do_reset(bit mt);
    in_valid = 1'b0;
    out_ready = 1'b0;
    rst_n = 1'b0;
    mt_mode = mt;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset(mt);
    #1;
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R8", int'(in_ready), 1);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: shared start
    do_reset(1'b0);
    issue(4'hF, 1, SPI, 0, 0, 0, 0, 8'h11, "R1", 100);
    drain();
    // R1: stack pointer unshared
    do_reset(1'b1);
    issue(4'hF, 1, SPI, 0, 0, 0, 0, 8'h12, "R1", 100);
    issue(4'hF, 1, 0, 0, 0, 0, 0, 8'h13, "R1", 100);
    drain();
    // R2: no sources
    issue(4'b1011, 0, SPI, 0, SPI, 0, 0, 8'h21, "R2", 100);
    issue(4'hF, 1, 0, 1, SPI, 0, 0, 8'h22, "R2", 100);
    drain();
    // R9: empty mask
    issue(4'h0, 1, SPI, 0, 0, 1, 3, 8'h91, "R9", 100);
    issue(4'hF, 1, 3, 0, 0, 0, 0, 8'h92, "R9", 100);
    drain();
    // R5 / R3 / R4 on register 2
    issue(4'hF, 1, SPI, 0, 0, 1, 2, 8'h51, "R5", 100);
    issue(4'b0110, 1, 2, 0, 0, 0, 0, 8'h31, "R3", 100);
    issue(4'b0011, 0, 0, 0, 0, 1, 2, 8'h52, "R5", 100);
    issue(4'hF, 1, 2, 0, 0, 0, 0, 8'h41, "R4", 100);
    drain();
    // R6: no destination, untouched pairs
    issue(4'hF, 1, SPI, 0, 0, 0, 0, 8'h61, "R6", 100);
    issue(4'hF, 1, 0, 0, 0, 0, 0, 8'h62, "R6", 100);
    issue(4'b0011, 1, SPI, 0, 0, 1, 0, 8'h63, "R6", 100);
    issue(4'b1100, 1, 0, 0, 0, 0, 0, 8'h64, "R6", 100);
    drain();
    // R7 / R8: back-pressure
    issue(4'hF, 1, SPI, 0, 0, 0, 0, 8'h71, "R7", 25);
    issue(4'hF, 1, SPI, 0, 0, 0, 0, 8'h81, "R8", 25);
    drain();
    // sweeps in both reset flavours
    for (int pass = 0; pass < 2; pass++) begin
      do_reset(pass == 0);
      for (int it = 0; it < 1600; it++) begin
        logic [31:0] r;
        r = nxt();
        issue(4'(it ^ int'(r[19:16])), r[0], int'(r[3:2]), r[1], int'(r[5:4]),
              r[6], int'(r[9:8]), TW'(r[31:24]), "R4", 70);
        if (it % 5 == 4) issue(4'(r[23:20]), 0, 0, 0, 0, 1, int'(r[11:10]), TW'(it), "R5", 70);
      end
      drain();
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule